// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block runs one DMA channel. A single load pulse delivers a command word, a source address, a destination address and a unit count. When the command word has its start bit set, the channel copies the programmed number of units from source to destination. Each unit is one read and then one write on a simple request/acknowledge memory port. A one-word holding register carries the read data to the write.

The command word sets several things. It gives the access width, which is shared by both sides. It gives how many units run between handshake checks. It gives separate source and destination address steps, which scale with the width, so a side can walk a buffer or stay on one device register. Up to two request lines can pace the transfer. While a selected line is low, the channel holds off before starting its next burst. At the end the channel clears its start bit and optionally raises a done flag. The address and count registers keep their final values.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset, `busy`, `mem_req`, `done_irq` and every register output are zero. A load with command bit 0 (start) clear stores the values and starts no memory access. A load with bit 0 set starts a transfer, and `busy` is high exactly while command bit 0 is set.
- R2: Command bit 3 set runs bursts of up to 4 units, and bit 3 clear runs 1 unit, between handshake checks. A burst already begun finishes even if its request line drops.
- R3: Command bits 21:20 choose the width: 0 gives 4 bytes, 1 gives 2 bytes, and 2 or 3 give 1 byte. `mem_size` carries log2 of the byte count (2, 1 or 0) on every access.
- R4: The source step comes from bits 9:8 and the destination step from bits 13:12. Code 0 keeps the address fixed. Codes 1, 2 and 3 add 1, 2 or 4 times the width in bytes after each unit on that side.
- R5: The 24-bit count is in units. It drops by one after each unit's write is acknowledged, and the transfer ends when it reaches zero. A start with count 0 finishes with no memory access.
- R6: On completion, command bit 0 is cleared. Bit 1 (`done_irq`) is set only if bit 2 (done enable) is set.
- R7: Bits 27:24 select the source request line and bits 19:16 the destination request line. Line 0 means no gating. A nonzero selected line that is low stalls the channel before its next burst, and the channel resumes when the line goes high.
- R8: When the transfer ends, `src_addr` and `dst_addr` hold the addresses that follow the last unit on each side.
- R9: Each unit is a read at the current source address (`mem_we`=0) followed by a write at the current destination address (`mem_we`=1) carrying the word that was read. A request holds its address, direction and data until `mem_ack`.
- R10: A load while `busy` is high is ignored, and the command, addresses and count are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load | input | 1 | Single-cycle strobe that writes the four fields below |
| load_cmd | input | 32 | Command word |
| load_src | input | 32 | Source start address |
| load_dst | input | 32 | Destination start address |
| load_count | input | 24 | Units to move |
| hs_req | input | 16 | Peripheral request lines, index = line number |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Access byte address |
| mem_size | output | 2 | log2 of access bytes |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access accepted this cycle; read data valid with it |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | Transfer in progress |
| done_irq | output | 1 | Done status (command bit 1) |
| cmd_word | output | 32 | Current command word |
| src_addr | output | 32 | Current source address |
| dst_addr | output | 32 | Current destination address |
| count | output | 24 | Remaining units |

## Verification
The copy is tried in several configurations. A 32-bit transfer with both sides incrementing checks data order and the final addresses. A 16-bit transfer with a fixed source and a destination step of four widths uses 4-unit bursts and a count that is not a multiple of four. An 8-bit transfer with a doubled source step and a fixed destination uses width code 3. Together these separate each width decode and each step code. A zero count shows that completion needs no access. A request line that is low from the start shows the stall and lets a busy-time load be checked for no effect. Dropping a line right after a transfer begins shows whether the stall comes after four units or after one, which tells the two burst settings apart.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_READ  = 2'd2,
    ST_WRITE = 2'd3
  } chan_state_t;

  localparam int CMD_W      = 32;
  localparam int BIT_START  = 0;
  localparam int BIT_DONE   = 1;
  localparam int BIT_DONEEN = 2;
  localparam int BIT_BURST  = 3;
  localparam int SEL_W      = 4;
endpackage

// File: rtl/dma_rst_sync.sv
module dma_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ni
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_ni = sync_q[1];
endmodule

// File: rtl/dma_cmd_decode.sv
module dma_cmd_decode
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BURST_MAX = 4
) (
  input  logic [CMD_W-1:0]  cmd,
  output logic [2:0]        burst_len,
  output logic [1:0]        size_log2,
  output logic [ADDR_W-1:0] src_step,
  output logic [ADDR_W-1:0] dst_step,
  output logic [SEL_W-1:0]  src_sel,
  output logic [SEL_W-1:0]  dst_sel
);
  logic [ADDR_W-1:0] unit_bytes;
  logic [1:0]        wcode, scode, dcode;

  assign wcode = cmd[21:20];
  assign scode = cmd[9:8];
  assign dcode = cmd[13:12];

  always_comb begin
    case (wcode)
      2'd0:    size_log2 = 2'd2;
      2'd1:    size_log2 = 2'd1;
      default: size_log2 = 2'd0;
    endcase
  end

  assign unit_bytes = ADDR_W'(1) << size_log2;
  assign burst_len  = cmd[BIT_BURST] ? 3'(BURST_MAX) : 3'd1;
  assign src_step   = (scode == 2'd0) ? '0 : (unit_bytes << (scode - 2'd1));
  assign dst_step   = (dcode == 2'd0) ? '0 : (unit_bytes << (dcode - 2'd1));
  assign src_sel    = cmd[27:24];
  assign dst_sel    = cmd[19:16];
endmodule

// File: rtl/dma_hs_gate.sv
module dma_hs_gate
  import dma_chan_pkg::*;
#(
  parameter int HS_LINES = 16
) (
  input  logic [HS_LINES-1:0] hs_req,
  input  logic [SEL_W-1:0]    src_sel,
  input  logic [SEL_W-1:0]    dst_sel,
  output logic                go
);
  localparam int SPAN = 1 << SEL_W;
  logic [SPAN-1:0] req_pad;

  generate
    if (HS_LINES < SPAN) begin : g_pad
      assign req_pad = {{(SPAN-HS_LINES){1'b0}}, hs_req};
    end else begin : g_full
      assign req_pad = hs_req[SPAN-1:0];
    end
  endgenerate

  logic src_ok, dst_ok;
  assign src_ok = (src_sel == '0) || req_pad[src_sel];
  assign dst_ok = (dst_sel == '0) || req_pad[dst_sel];
  assign go     = src_ok && dst_ok;
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 24,
  parameter int HS_LINES  = 16,
  parameter int BURST_MAX = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [CMD_W-1:0]    load_cmd,
  input  logic [ADDR_W-1:0]   load_src,
  input  logic [ADDR_W-1:0]   load_dst,
  input  logic [CNT_W-1:0]    load_count,
  input  logic [HS_LINES-1:0] hs_req,
  output logic                mem_req,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [1:0]          mem_size,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic                mem_ack,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic                busy,
  output logic                done_irq,
  output logic [CMD_W-1:0]    cmd_word,
  output logic [ADDR_W-1:0]   src_addr,
  output logic [ADDR_W-1:0]   dst_addr,
  output logic [CNT_W-1:0]    count
);
  logic rst_ni;
  dma_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_ni(rst_ni));

  chan_state_t       state_q, state_d;
  logic [CMD_W-1:0]  cmd_q, cmd_d;
  logic [ADDR_W-1:0] src_q, src_d, dst_q, dst_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [2:0]        beats_q, beats_d;
  logic [DATA_W-1:0] hold_q;
  logic              hold_en;

  logic [2:0]        burst_len;
  logic [1:0]        size_log2;
  logic [ADDR_W-1:0] src_step, dst_step;
  logic [SEL_W-1:0]  src_sel, dst_sel;
  logic              gate_go;

  dma_cmd_decode #(.ADDR_W(ADDR_W), .BURST_MAX(BURST_MAX)) u_dec (
    .cmd(cmd_q), .burst_len(burst_len), .size_log2(size_log2),
    .src_step(src_step), .dst_step(dst_step),
    .src_sel(src_sel), .dst_sel(dst_sel)
  );

  dma_hs_gate #(.HS_LINES(HS_LINES)) u_gate (
    .hs_req(hs_req), .src_sel(src_sel), .dst_sel(dst_sel), .go(gate_go)
  );

  logic load_acc;
  assign load_acc = load && !cmd_q[BIT_START];

  // next-state logic
  always_comb begin
    state_d = state_q;
    cmd_d   = cmd_q;
    src_d   = src_q;
    dst_d   = dst_q;
    cnt_d   = cnt_q;
    beats_d = beats_q;
    hold_en = 1'b0;
    mem_req = 1'b0;
    mem_we  = 1'b0;
    mem_addr = src_q;
    case (state_q)
      ST_IDLE: begin
        if (load_acc) begin
          cmd_d = load_cmd;
          src_d = load_src;
          dst_d = load_dst;
          cnt_d = load_count;
        end else if (cmd_q[BIT_START]) begin
          state_d = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (cnt_q == '0) begin
          cmd_d[BIT_START] = 1'b0;
          if (cmd_q[BIT_DONEEN]) cmd_d[BIT_DONE] = 1'b1;
          state_d = ST_IDLE;
        end else if (gate_go) begin
          beats_d = (cnt_q < CNT_W'(burst_len)) ? cnt_q[2:0] : burst_len;
          state_d = ST_READ;
        end
      end
      ST_READ: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          hold_en = 1'b1;
          src_d   = src_q + src_step;
          state_d = ST_WRITE;
        end
      end
      ST_WRITE: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = dst_q;
        if (mem_ack) begin
          dst_d   = dst_q + dst_step;
          cnt_d   = cnt_q - 1'b1;
          beats_d = beats_q - 3'd1;
          state_d = (beats_q == 3'd1) ? ST_CHECK : ST_READ;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cmd_q   <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      cnt_q   <= '0;
      beats_q <= '0;
    end else begin
      state_q <= state_d;
      cmd_q   <= cmd_d;
      src_q   <= src_d;
      dst_q   <= dst_d;
      cnt_q   <= cnt_d;
      beats_q <= beats_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)      hold_q <= '0;
    else if (hold_en) hold_q <= mem_rdata;
  end

  assign mem_size  = size_log2;
  assign mem_wdata = hold_q;
  assign busy      = cmd_q[BIT_START];
  assign done_irq  = cmd_q[BIT_DONE];
  assign cmd_word  = cmd_q;
  assign src_addr  = src_q;
  assign dst_addr  = dst_q;
  assign count     = cnt_q;

  // assertions
  a_r1_no_access_when_stopped: assert property (@(posedge clk) disable iff (!rst_ni)
    !busy |-> !mem_req);

  a_r9_req_held: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  a_r5_count_per_unit: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_req && mem_we && mem_ack |=> count == $past(count) - 1'b1);

  a_r6_done_gated: assert property (@(posedge clk) disable iff (!rst_ni)
    !load && $rose(done_irq) |=> !busy && cmd_word[BIT_DONEEN]);

  a_r10_busy_load_ignored: assert property (@(posedge clk) disable iff (!rst_ni)
    busy && load |=> cmd_word[CMD_W-1:BIT_BURST] == $past(cmd_word[CMD_W-1:BIT_BURST]));

  a_r7_stall_when_gated: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_CHECK) && !gate_go && (cnt_q != '0) |=> !mem_req);
endmodule

// File: tb/dma_chan_engine_tb_top.sv
module dma_chan_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [31:0] load_cmd = '0, load_src = '0, load_dst = '0;
  logic [23:0] load_count = '0;
  logic [15:0] hs_req = '0;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [1:0]  mem_size;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        busy, done_irq;
  logic [31:0] cmd_word, src_addr, dst_addr;
  logic [23:0] count;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_engine dut_i (
    .clk(clk), .rst_n(rst_n), .load(load), .load_cmd(load_cmd),
    .load_src(load_src), .load_dst(load_dst), .load_count(load_count),
    .hs_req(hs_req), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .busy(busy), .done_irq(done_irq),
    .cmd_word(cmd_word), .src_addr(src_addr), .dst_addr(dst_addr), .count(count)
  );

  typedef struct packed {
    logic        we;
    logic [31:0] addr;
    logic [31:0] data;
    logic [1:0]  size;
  } acc_t;

  acc_t exp_q[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  int   n_acc    = 0;
  int   cyc      = 0;

  function automatic logic [31:0] pat(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // memory model and monitor
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_req) begin
      acc_t e;
      mem_ack = 1'b1;
      mem_rdata = pat(mem_addr);
      n_acc++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9 unexpected access", mem_addr, 32'h0);
      end else begin
        e = exp_q.pop_front();
        chk(mem_we == e.we, "R9 direction", 32'(mem_we), 32'(e.we));
        chk(mem_addr == e.addr, "R4 address", mem_addr, e.addr);
        chk(mem_size == e.size, "R3 size", 32'(mem_size), 32'(e.size));
        if (e.we) chk(mem_wdata == e.data, "R9 write data", mem_wdata, e.data);
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WD_LIMIT);
      finish_run();
    end
  end

  task automatic do_load(input logic [31:0] c, input logic [31:0] s,
                         input logic [31:0] d, input logic [23:0] n);
    @(negedge clk);
    load = 1'b1; load_cmd = c; load_src = s; load_dst = d; load_count = n;
    @(negedge clk);
    load = 1'b0;
  endtask

  // driver: compute the expected access list, final addresses; start
  task automatic push_xfer(input logic [31:0] c, input logic [31:0] s,
                           input logic [31:0] d, input logic [23:0] n,
                           output logic [31:0] s_end, output logic [31:0] d_end);
    logic [1:0]  sz;
    logic [31:0] bytes, ss, ds;
    case (c[21:20])
      2'd0: sz = 2'd2;
      2'd1: sz = 2'd1;
      default: sz = 2'd0;
    endcase
    bytes = 32'd1 << sz;
    ss = (c[9:8] == 2'd0) ? 32'd0 : (c[9:8] == 2'd1) ? bytes : (c[9:8] == 2'd2) ? 2*bytes : 4*bytes;
    ds = (c[13:12] == 2'd0) ? 32'd0 : (c[13:12] == 2'd1) ? bytes : (c[13:12] == 2'd2) ? 2*bytes : 4*bytes;
    for (int u = 0; u < int'(n); u++) begin
      exp_q.push_back('{we: 1'b0, addr: s, data: 32'h0, size: sz});
      exp_q.push_back('{we: 1'b1, addr: d, data: pat(s), size: sz});
      s = s + ss;
      d = d + ds;
    end
    s_end = s;
    d_end = d;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
  endtask

  task automatic end_check(input logic [31:0] se, input logic [31:0] de,
                           input bit den);
    chk(!busy && !cmd_word[0], "R6 start cleared", cmd_word, 32'h0);
    chk(done_irq == den, "R6 done flag", 32'(done_irq), 32'(den));
    chk(count == 24'd0, "R5 count zero", 32'(count), 32'h0);
    chk(src_addr == se, "R8 final source", src_addr, se);
    chk(dst_addr == de, "R8 final destination", dst_addr, de);
    chk(exp_q.size() == 0, "R9 all units issued", 32'(exp_q.size()), 32'h0);
  endtask

  initial begin
    logic [31:0] se, de, c;
    int a0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(!busy && !mem_req && !done_irq, "R1 reset outputs", {busy, mem_req, done_irq}, 32'h0);
    chk(cmd_word == 0 && src_addr == 0 && dst_addr == 0 && count == 0, "R1 reset registers",
        cmd_word | src_addr | dst_addr, 32'h0);

    // R1 load without start
    a0 = n_acc;
    do_load(32'h0000_1104, 32'h100, 32'h200, 24'd7);
    repeat (10) @(negedge clk);
    chk(n_acc == a0 && !busy, "R1 no start no access", 32'(n_acc - a0), 32'h0);
    chk(cmd_word == 32'h0000_1104 && count == 24'd7, "R1 stored values", cmd_word, 32'h0000_1104);

    // R3 R4 R9: 32-bit, both increment, burst 1, done enabled, count 5
    c = 32'h0000_1105;
    push_xfer(c, 32'h1000, 32'h2000, 24'd5, se, de);
    do_load(c, 32'h1000, 32'h2000, 24'd5);
    wait_idle();
    end_check(se, de, 1'b1);

    // R2 R3 R4: 16-bit, fixed source, destination 4x step, burst 4, no done enable, count 6
    c = 32'h0010_3009;
    push_xfer(c, 32'h3000, 32'h4000, 24'd6, se, de);
    do_load(c, 32'h3000, 32'h4000, 24'd6);
    wait_idle();
    end_check(se, de, 1'b0);

    // R3 R4: 8-bit via code 3, source 2x step, fixed destination, count 3
    c = 32'h0030_0205;
    push_xfer(c, 32'h5001, 32'h6003, 24'd3, se, de);
    do_load(c, 32'h5001, 32'h6003, 24'd3);
    wait_idle();
    end_check(se, de, 1'b1);

    // R5 count zero: no access, completes
    a0 = n_acc;
    do_load(32'h0000_1105, 32'h7000, 32'h8000, 24'd0);
    wait_idle();
    chk(n_acc == a0, "R5 zero count no access", 32'(n_acc - a0), 32'h0);
    end_check(32'h7000, 32'h8000, 1'b1);

    // R7 stall on source line 3; R10 load while busy ignored
    hs_req = 16'h0000;
    c = 32'h0300_1105;
    push_xfer(c, 32'h9000, 32'hA000, 24'd2, se, de);
    a0 = n_acc;
    do_load(c, 32'h9000, 32'hA000, 24'd2);
    repeat (20) @(negedge clk);
    chk(n_acc == a0 && busy, "R7 stalled while line low", 32'(n_acc - a0), 32'h0);
    do_load(32'h0000_0000, 32'hDEAD_0000, 32'hBEEF_0000, 24'd9);
    @(negedge clk);
    chk(cmd_word == c && src_addr == 32'h9000 && count == 24'd2, "R10 busy load ignored",
        src_addr, 32'h9000);
    hs_req[3] = 1'b1;
    wait_idle();
    end_check(se, de, 1'b1);

    // R2 burst 4: destination line 5 drops after first access, 4 units complete
    hs_req = 16'h0020;
    c = 32'h0005_110D;
    push_xfer(c, 32'hB000, 32'hC000, 24'd6, se, de);
    a0 = n_acc;
    do_load(c, 32'hB000, 32'hC000, 24'd6);
    while (n_acc == a0) @(negedge clk);
    hs_req[5] = 1'b0;
    repeat (40) @(negedge clk);
    chk(count == 24'd2 && busy, "R2 burst of four then stall", 32'(count), 32'd2);
    hs_req[5] = 1'b1;
    wait_idle();
    end_check(se, de, 1'b1);

    // R2 burst 1: same drop, one unit then stall
    c = 32'h0005_1105;
    push_xfer(c, 32'hD000, 32'hE000, 24'd3, se, de);
    a0 = n_acc;
    do_load(c, 32'hD000, 32'hE000, 24'd3);
    while (n_acc == a0) @(negedge clk);
    hs_req[5] = 1'b0;
    repeat (40) @(negedge clk);
    chk(count == 24'd2 && busy, "R2 single unit then stall", 32'(count), 32'd2);
    hs_req[5] = 1'b1;
    wait_idle();
    end_check(se, de, 1'b1);

    finish_run();
  end
endmodule